// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block sits between a frame-buffer fetch engine and a colour stage. It takes a stream of 32-bit memory words and hands out one pixel per accepted transfer. A three-bit depth code sets the bits per pixel to 1, 2, 4, 8, 16 or 32. At the four narrow depths the output carries a palette index for a lookup stage further down. At 16 and 32 bits the output carries direct colour, widened to three 8-bit channels.

Two ordering controls set where each pixel sits inside a word: fully big-endian, or little-endian bytes with the pixels in each byte taken from the top. When both controls are set, fully big-endian wins. A colour-order input either keeps the channel order of direct-colour pixels or exchanges the outer two channels.

The block also gives the length of one panel line in bytes for the chosen depth. It marks the last pixel of every line, counting pixels from the panel width. Both the word input and the pixel output use valid/ready handshakes. A word is released only once all of its pixels have been taken downstream. The configuration inputs are held steady while a stream is in flight.

Top module: `pix_unpack`

## Requirements
- R1: While reset is asserted and just after it is released, `pix_valid_o` is 0 and `word_ready_o` is 1.
- R2: Depth codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bits per pixel. The pixel value is a palette index in `pix_o[7:0]` and bits 23:8 are zero. Codes 6 and 7 act exactly like code 3.
- R3: With both ordering controls clear, pixel k of a word at b bits per pixel is `word[k*b +: b]`, so pixels start at the least significant bit.
- R4: With `be_byte_i` set, pixel k is `word[32-(k+1)*b +: b]`, so pixels start at the most significant bit. This holds whatever `be_pix_i` is.
- R5: With only `be_pix_i` set and b below 8, bytes are taken in little-endian order and pixels within each byte start at its top bit: pixel k is at bit offset 8*floor(k*b/8) + 8 - b - (k*b mod 8). At 8, 16 and 32 bits this mode matches R3.
- R6: At depth code 5 the channels are c0=`word[7:0]`, c1=`word[15:8]` and c2=`word[23:16]`, and `word[31:24]` is ignored. With `bgr_order_i`=1, `pix_o`={c2,c1,c0}. With `bgr_order_i`=0, `pix_o`={c0,c1,c2}.
- R7: At depth code 4 the 16-bit pixel holds c0=bits[4:0], c1=bits[9:5] and c2=bits[14:10], and bit 15 is ignored. Each channel is widened to {c,3'b000}, then placed as in R6.
- R8: `stride_o` equals the width shifted right by 3, 2 or 1 for codes 0, 1 and 2. It equals the width for codes 3, 6 and 7. It equals the width shifted left by 1 or 2 for codes 4 and 5.
- R9: Each word yields 32/b pixels in order. A new word is accepted only in a cycle where no pixel is pending, or where the last pixel of the held word is being accepted.
- R10: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the next cycle still shows `pix_valid_o`=1 with the same `pix_o`.
- R11: `pix_eol_o` is 1 on exactly the pixels whose index since reset, taken modulo `width_i`, equals `width_i`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_i | input | 3 | Pixel-depth code |
| be_byte_i | input | 1 | Fully big-endian pixel order (takes priority) |
| be_pix_i | input | 1 | Little-endian bytes, pixels from the top of each byte |
| bgr_order_i | input | 1 | Keep channel order of direct-colour pixels (0 exchanges outer channels) |
| width_i | input | PIX_CNT_W | Panel width in pixels |
| stride_o | output | PIX_CNT_W+2 | Line length in bytes |
| word_valid_i | input | 1 | Input word valid |
| word_ready_o | output | 1 | Input word accepted when valid |
| word_i | input | 32 | Frame-buffer word |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Downstream accepts the pixel |
| pix_o | output | 24 | Palette index (low byte) or direct colour |
| pix_eol_o | output | 1 | Last pixel of a panel line |

## Verification
Some properties are checked on every cycle: index modes leave the upper 16 output bits at zero, 16-bit channels keep their three low bits at zero, and stalls hold the output valid. A word is never taken over unconsumed pixels, and end-of-line marks are spaced exactly one width apart. The stride for 32-bit pixels is a multiple of four. Only the bench scenarios can show that each pixel comes from the right field of the right word in every ordering mode. The same goes for the precedence of fully big-endian order, the channel exchange, codes 6 and 7 acting as 8-bit, and the exact stride values.

// File: rtl/pu_pkg.sv
package pu_pkg;
   localparam int WORD_W   = 32;
   localparam int PIX_W    = 24;
   localparam int DEPTHS   = 6;
   localparam int IDX_W    = $clog2(WORD_W);

   typedef enum logic [2:0] {
      DEP_1  = 3'd0,
      DEP_2  = 3'd1,
      DEP_4  = 3'd2,
      DEP_8  = 3'd3,
      DEP_16 = 3'd4,
      DEP_32 = 3'd5
   } depth_e;

   // codes above the last defined one fall back to 8 bits per pixel
   function automatic depth_e norm_depth(input logic [2:0] code);
      if (code > 3'd5) return DEP_8;
      return depth_e'(code);
   endfunction
endpackage

// File: rtl/pu_stride.sv
module pu_stride
   import pu_pkg::*;
#(
   parameter int PIX_CNT_W = 11,
   localparam int STRIDE_W = PIX_CNT_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  depth_e               depth,
   input  logic [PIX_CNT_W-1:0] width,
   output logic [STRIDE_W-1:0]  stride
);
   logic [STRIDE_W-1:0] w_ext;
   assign w_ext = STRIDE_W'(width);

   always_comb begin
      unique case (depth)
         DEP_1:   stride = w_ext >> 3;
         DEP_2:   stride = w_ext >> 2;
         DEP_4:   stride = w_ext >> 1;
         DEP_8:   stride = w_ext;
         DEP_16:  stride = w_ext << 1;
         default: stride = w_ext << 2;
      endcase
   end

   AST_STRIDE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == DEP_32) |-> (stride[1:0] == 2'b00)); // R8
endmodule

// File: rtl/pu_fieldsel.sv
module pu_fieldsel
   import pu_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  depth_e            depth,
   input  logic              be_byte,
   input  logic              be_pix,
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] field
);
   logic [WORD_W-1:0] lane [DEPTHS];

   for (genvar g = 0; g < DEPTHS; g++) begin : g_lane
      localparam int B = 1 << g;
      localparam logic [WORD_W-1:0] MASK =
         (B == WORD_W) ? '1 : ((WORD_W'(1) << B) - WORD_W'(1));
      logic [IDX_W:0] off_le;
      logic [IDX_W:0] off;
      logic [WORD_W-1:0] shifted;

      always_comb begin
         off_le = (IDX_W+1)'(idx) << g;
         if (be_byte) begin
            off = (IDX_W+1)'(WORD_W - B) - off_le;
         end else if (be_pix && (B < 8)) begin
            off = {off_le[IDX_W:3], 3'b000} + (IDX_W+1)'(8 - B)
                  - (IDX_W+1)'(off_le[2:0]);
         end else begin
            off = off_le;
         end
         shifted = word >> off;
      end
      assign lane[g] = shifted & MASK;
   end

   assign field = lane[int'(depth)];
endmodule

// File: rtl/pu_colour.sv
module pu_colour
   import pu_pkg::*;
(
   input  logic [WORD_W-1:0] field,
   input  depth_e            depth,
   input  logic              bgr_order,
   output logic [PIX_W-1:0]  pix
);
   logic [7:0] c0, c1, c2;

   always_comb begin
      c0 = '0;
      c1 = '0;
      c2 = '0;
      pix = '0;
      if (depth == DEP_16) begin
         c0 = {field[4:0],   3'b000};
         c1 = {field[9:5],   3'b000};
         c2 = {field[14:10], 3'b000};
      end else if (depth == DEP_32) begin
         c0 = field[7:0];
         c1 = field[15:8];
         c2 = field[23:16];
      end
      if (depth == DEP_16 || depth == DEP_32) begin
         pix = bgr_order ? {c2, c1, c0} : {c0, c1, c2};
      end else begin
         pix = {16'h0000, field[7:0]};
      end
   end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pu_pkg::*;
#(
   parameter int PIX_CNT_W = 11,
   localparam int STRIDE_W = PIX_CNT_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           depth_i,
   input  logic                 be_byte_i,
   input  logic                 be_pix_i,
   input  logic                 bgr_order_i,
   input  logic [PIX_CNT_W-1:0] width_i,
   output logic [STRIDE_W-1:0]  stride_o,
   input  logic                 word_valid_i,
   output logic                 word_ready_o,
   input  logic [31:0]          word_i,
   output logic                 pix_valid_o,
   input  logic                 pix_ready_i,
   output logic [23:0]          pix_o,
   output logic                 pix_eol_o
);
   initial begin
      assert (PIX_CNT_W >= 2 && PIX_CNT_W <= 16)
         else $error("PIX_CNT_W out of range");
      assert (WORD_W == 32 && PIX_W == 24)
         else $error("package widths changed");
   end

   depth_e depth;
   assign depth = norm_depth(depth_i);

   logic [WORD_W-1:0]  word_q;
   logic               have_q;
   logic [IDX_W-1:0]   idx_q;
   logic [PIX_CNT_W-1:0] col_q;
   logic [IDX_W-1:0]   idx_last;
   logic               last_in_word;
   logic               pix_fire, word_fire;
   logic [WORD_W-1:0]  field;

   assign idx_last     = IDX_W'((WORD_W >> int'(depth)) - 1);
   assign last_in_word = (idx_q == idx_last);
   assign pix_valid_o  = have_q;
   assign pix_fire     = have_q & pix_ready_i;
   assign word_ready_o = ~have_q | (pix_ready_i & last_in_word);
   assign word_fire    = word_valid_i & word_ready_o;
   assign pix_eol_o    = have_q &
      ((PIX_CNT_W+1)'(col_q) + (PIX_CNT_W+1)'(1) == (PIX_CNT_W+1)'(width_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         have_q <= 1'b0;
         idx_q  <= '0;
      end else if (word_fire) begin
         word_q <= word_i;
         have_q <= 1'b1;
         idx_q  <= '0;
      end else if (pix_fire) begin
         if (last_in_word) begin
            have_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q  <= idx_q + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               col_q <= '0;
      else if (pix_fire)        col_q <= pix_eol_o ? '0 : col_q + PIX_CNT_W'(1);
   end

   pu_stride #(.PIX_CNT_W(PIX_CNT_W)) u_stride (
      .clk(clk), .rst_n(rst_n), .depth(depth), .width(width_i), .stride(stride_o)
   );

   pu_fieldsel u_sel (
      .word(word_q), .depth(depth), .be_byte(be_byte_i), .be_pix(be_pix_i),
      .idx(idx_q), .field(field)
   );

   pu_colour u_col (
      .field(field), .depth(depth), .bgr_order(bgr_order_i), .pix(pix_o)
   );

   // independent tallies used only by the properties below
   logic [IDX_W:0]     chk_taken;
   logic [PIX_CNT_W:0] chk_gap;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_taken <= '0;
         chk_gap   <= '0;
      end else begin
         if (word_fire)     chk_taken <= '0;
         else if (pix_fire) chk_taken <= chk_taken + (IDX_W+1)'(1);
         if (pix_fire)      chk_gap <= pix_eol_o ? '0 : chk_gap + (PIX_CNT_W+1)'(1);
      end
   end

   AST_INDEX_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_o && depth < DEP_16) |-> (pix_o[23:8] == 16'h0000)); // R2
   AST_EXPAND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_o && depth == DEP_16) |->
      (pix_o[2:0] == 3'b0 && pix_o[10:8] == 3'b0 && pix_o[18:16] == 3'b0)); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_o && !pix_ready_i) |=> pix_valid_o); // R10
   AST_WORD_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (word_fire && have_q) |->
      (pix_fire && (chk_taken + (IDX_W+1)'(1) == (IDX_W+1)'(WORD_W >> int'(depth))))); // R9
   AST_EOL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_fire && pix_eol_o) |->
      (chk_gap + (PIX_CNT_W+1)'(1) == (PIX_CNT_W+1)'(width_i))); // R11
endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;
   localparam int WP    = 11;
   localparam int LIMIT = 150000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    depth_i;
   logic          be_byte_i, be_pix_i, bgr_order_i;
   logic [WP-1:0] width_i;
   logic [WP+1:0] stride_o;
   logic          word_valid_i, word_ready_o;
   logic [31:0]   word_i;
   logic          pix_valid_o, pix_ready_i, pix_eol_o;
   logic [23:0]   pix_o;

   pix_unpack #(.PIX_CNT_W(WP)) u0 (
      .clk(clk), .rst_n(rst_n), .depth_i(depth_i), .be_byte_i(be_byte_i),
      .be_pix_i(be_pix_i), .bgr_order_i(bgr_order_i), .width_i(width_i),
      .stride_o(stride_o), .word_valid_i(word_valid_i), .word_ready_o(word_ready_o),
      .word_i(word_i), .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i),
      .pix_o(pix_o), .pix_eol_o(pix_eol_o)
   );

   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit hung   = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int eff_depth(input int dep);
      return (dep > 5) ? 3 : dep;   // R2: codes 6 and 7 act as 8 bpp
   endfunction

   function automatic logic [23:0] ref_pix(input logic [31:0] w, input int k,
         input int dep, input bit be, input bit bp, input bit bgr);
      int b = 1 << eff_depth(dep);
      int off;
      logic [31:0] f;
      logic [7:0] c0, c1, c2;
      if (be)                 off = 32 - (k + 1) * b;
      else if (bp && b < 8)   off = ((k * b) / 8) * 8 + 8 - b - ((k * b) % 8);
      else                    off = k * b;
      f = w >> off;
      if (b <= 8) return {16'h0000, f[7:0] & 8'((1 << b) - 1)};
      if (b == 16) begin
         c0 = {f[4:0], 3'b000}; c1 = {f[9:5], 3'b000}; c2 = {f[14:10], 3'b000};
      end else begin
         c0 = f[7:0]; c1 = f[15:8]; c2 = f[23:16];
      end
      return bgr ? {c2, c1, c0} : {c0, c1, c2};
   endfunction

   function automatic logic [WP+1:0] ref_stride(input int width, input int dep);
      int d = eff_depth(dep);
      int s;
      case (d)
         0: s = width >> 3;
         1: s = width >> 2;
         2: s = width >> 1;
         3: s = width;
         4: s = width << 1;
         default: s = width << 2;
      endcase
      return (WP+2)'(s);
   endfunction

   function automatic string tag_of(input int dep, input bit be, input bit bp);
      int d = eff_depth(dep);
      if (dep > 5)          return "R2";
      if (be)               return "R4";
      if (bp && d < 3)      return "R5";
      if (d == 5)           return "R6";
      if (d == 4)           return "R7";
      return "R3";
   endfunction

   task automatic run(input int dep, input bit be, input bit bp, input bit bgr,
                      input int width, input int nw);
      logic [31:0] words [16];
      int n = 32 >> eff_depth(dep);
      int total = nw * n;
      int sent = 0;
      int p = 0;
      bit stall_prev = 0;
      logic [23:0] prev_pix = '0;
      for (int i = 0; i < 16; i++) words[i] = $urandom;
      @(negedge clk);
      depth_i = 3'(dep); be_byte_i = be; be_pix_i = bp; bgr_order_i = bgr;
      width_i = WP'(width);
      rst_n = 1'b0; word_valid_i = 1'b0; pix_ready_i = 1'b0; word_i = '0;
      @(negedge clk);
      #1;
      chk(!pix_valid_o, "R1", 32'(pix_valid_o), 0);
      chk(word_ready_o, "R1", 32'(word_ready_o), 1);
      chk(stride_o == ref_stride(width, dep), "R8", 32'(stride_o),
          32'(ref_stride(width, dep)));
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!pix_valid_o && word_ready_o, "R1", {pix_valid_o, word_ready_o}, 32'b01);
      while (p < total && !hung) begin
         @(negedge clk);
         cyc++;
         if (cyc > LIMIT) begin
            hung = 1;
            chk(0, "watchdog", cyc, LIMIT);
         end
         word_valid_i = (sent < nw) && ($urandom % 4 != 0);
         word_i       = (sent < nw) ? words[sent] : 32'h0;
         pix_ready_i  = ($urandom % 3 != 0);
         #1;
         if (stall_prev)
            chk(pix_valid_o && pix_o == prev_pix, "R10", 32'(pix_o), 32'(prev_pix));
         if (word_valid_i && word_ready_o) begin
            chk(sent * n == p + ((pix_valid_o && pix_ready_i) ? 1 : 0), "R9",
                sent * n, p);
            sent++;
         end
         if (pix_valid_o && pix_ready_i) begin
            logic [23:0] e;
            e = ref_pix(words[p / n], p % n, dep, be, bp, bgr);
            chk(pix_o == e, tag_of(dep, be, bp), 32'(pix_o), 32'(e));
            chk(pix_eol_o == ((p % width) == width - 1), "R11",
                32'(pix_eol_o), 32'((p % width) == width - 1));
            p++;
         end
         stall_prev = pix_valid_o && !pix_ready_i;
         prev_pix   = pix_o;
      end
      word_valid_i = 1'b0;
      pix_ready_i  = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; word_valid_i = 0; pix_ready_i = 0; word_i = 0;
      depth_i = 0; be_byte_i = 0; be_pix_i = 0; bgr_order_i = 1; width_i = 8;
      // directed corners
      run(0, 0, 0, 1, 8, 2);      // R3 1 bpp little-endian
      run(1, 0, 1, 1, 5, 2);      // R5 2 bpp pixel-swapped bytes
      run(2, 1, 1, 0, 7, 2);      // R4 precedence over R5
      run(3, 0, 1, 0, 3, 3);      // R5 at 8 bpp equals R3
      run(4, 0, 0, 0, 1, 4);      // R7 with exchange, R11 every pixel
      run(4, 1, 0, 1, 6, 4);      // R7 big-endian
      run(5, 0, 0, 1, 4, 4);      // R6 keep order
      run(5, 0, 0, 0, 2047, 3);   // R6 exchange, R8 maximum width
      run(6, 0, 0, 1, 9, 3);      // R2 code 6
      run(7, 1, 0, 1, 10, 3);     // R2 code 7
      run(0, 0, 1, 1, 2047, 1);   // R8 narrow-depth stride
      // constrained random
      for (int r = 0; r < 24 && !hung; r++) begin
         run($urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2,
             1 + $urandom % 60, 1 + $urandom % 12);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule